// File: doc/BRIEF.md
# Dual-Channel Offset Search Sequencer

This block finds the correction codes that null the residual DC difference on the two paths of a quadrature receiver, I and Q. After a start request it runs a timed sequence on its own. The sequence is one quiet cycle that lets the calibration clock settle, four cycles with both codes parked at midscale, and eight search cycles. The two 8-bit codes are refined side by side in those search cycles, each from its own comparator sign, with a step that halves every cycle. When the sequence ends, the block pulses a done flag and reports whether each channel finished against an end of its range.

One "cycle" of the sequence is a programmable number of calibration-clock periods. Those periods reach the block as single-clock tick enables, either from an internal oscillator or from an external serial clock, so all logic runs in the system clock domain. The user selects the source and picks one of four averaging lengths per cycle. Longer cycles give the detector more time to average, and shorter ones make the calibration converge sooner.

Top module: `offset_search_ctrl`

## Requirements
- R1: After synchronous reset both codes are 128, and `busy_o`, `done_o`, `rail_i_o` and `rail_q_o` are 0.
- R2: A high `cal_start_i` sampled while not busy raises `busy_o` at the next clock. A start sampled while busy is ignored: the running sequence keeps its timing and no extra run follows it.
- R3: Each sequence cycle lasts N ticks of the selected source, with `div_sel_i` 0 → 1024, 1 → 512, 2 → 256 and 3 → 128. The selection is captured when a start is accepted.
- R4: `ext_sel_i` = 1 counts `ext_tick_i` and ignores `int_tick_i`. `ext_sel_i` = 0 counts `int_tick_i` and ignores `ext_tick_i`. The selection is captured when a start is accepted.
- R5: During the first cycle after a start, both codes keep their previous values.
- R6: At the end of the first cycle both codes become 128, and they stay 128 through cycles 2 to 5.
- R7: At the end of each of cycles 6 to 12 each channel samples its own sign: 1 (difference positive or exactly zero) adds the step and 0 subtracts it. The steps are 64, 32, 16, 8, 4, 2 and 1, in that order.
- R8: Cycle 13 changes no code. At its end `busy_o` falls and `done_o` is high for exactly one clock. With one tick per clock, done is seen 13·N clocks after the start edge.
- R9: When done is high, each rail flag is 1 if that channel's code is 255 or 1, and 0 otherwise. The flags hold until the next accepted start, which clears them.
- R10: Neither code ever takes the value 0.
- R11: While not busy, the codes hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_start_i | input | 1 | Request to start a calibration |
| ext_sel_i | input | 1 | 1: external tick source, 0: internal |
| int_tick_i | input | 1 | One-clock enable per internal oscillator period |
| ext_tick_i | input | 1 | One-clock enable per external serial clock period |
| div_sel_i | input | 2 | Ticks per sequence cycle (0:1024, 1:512, 2:256, 3:128) |
| sign_i_i | input | 1 | I residual sign, 1 = positive or zero |
| sign_q_i | input | 1 | Q residual sign, 1 = positive or zero |
| code_i_o | output | 8 | I correction code |
| code_q_o | output | 8 | Q correction code |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-clock end-of-sequence pulse |
| rail_i_o | output | 1 | I code ended at 255 or 1 |
| rail_q_o | output | 1 | Q code ended at 255 or 1 |

## Verification
Two events can fall on one clock edge: a new start request, and the final tick that ends cycle 13. The bench raises `cal_start_i` so that it is sampled on exactly the edge where the sequence finishes. It then expects `done_o` to pulse once and `busy_o` to stay low afterwards, so the late request is ignored and not queued. A separate start is also injected during the preset phase, and the bench checks that the completion time of that run still matches the count from the first start.

// File: rtl/offset_search_pkg.sv
`timescale 1ns/1ps
package offset_search_pkg;
  typedef enum logic [1:0] {
    PH_OFF    = 2'd0,
    PH_WAIT   = 2'd1,
    PH_PRESET = 2'd2,
    PH_SEARCH = 2'd3
  } phase_e;
endpackage

// File: rtl/offset_tick_div.sv
`timescale 1ns/1ps
module offset_tick_div #(
  parameter int BASE_LOG2 = 7,
  parameter int SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             ext_sel_i,
  input  logic             int_tick_i,
  input  logic             ext_tick_i,
  output logic             cyc_end_o
);
  localparam int SHIFT_MAX = (1 << SEL_W) - 1;
  localparam int CNT_W     = BASE_LOG2 + SHIFT_MAX;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_m1_q;
  logic [CNT_W:0]   lim_w;
  logic             ext_q;
  logic             tick;

  always_comb begin
    lim_w     = {{CNT_W{1'b0}}, 1'b1} << (BASE_LOG2 + SHIFT_MAX - int'(sel_i));
    tick      = ext_q ? ext_tick_i : int_tick_i;
    cyc_end_o = run_i && tick && (cnt_q == lim_m1_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      lim_m1_q <= '1;
      ext_q    <= 1'b0;
    end else begin
      if (load_i) begin
        lim_m1_q <= lim_w[CNT_W-1:0] - CNT_W'(1);
        ext_q    <= ext_sel_i;
      end
      if (!run_i)          cnt_q <= '0;
      else if (cyc_end_o)  cnt_q <= '0;
      else if (tick)       cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/offset_seq.sv
`timescale 1ns/1ps
module offset_seq
  import offset_search_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int PRESET_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              cyc_end_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              accept_o,
  output logic              preset_o,
  output logic              apply_o,
  output logic              finish_o,
  output logic [CODE_W-1:0] step_o
);
  localparam int SRCH_CYC = CODE_W;
  localparam int CNT_W    = $clog2(PRESET_CYC + SRCH_CYC);
  localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRESET_CYC - 1);
  localparam logic [CNT_W-1:0] SRCH_LAST = CNT_W'(SRCH_CYC - 1);
  localparam logic [CNT_W-1:0] SH_TOP    = CNT_W'(CODE_W - 2);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] sh;
  logic             busy_q, done_q;

  always_comb begin
    accept_o = (phase_q == PH_OFF) && start_i;
    preset_o = (phase_q == PH_WAIT) && cyc_end_i;
    apply_o  = (phase_q == PH_SEARCH) && cyc_end_i && (cnt_q != SRCH_LAST);
    finish_o = (phase_q == PH_SEARCH) && cyc_end_i && (cnt_q == SRCH_LAST);
    sh       = SH_TOP - cnt_q;
    step_o   = CODE_W'(1) << sh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_OFF;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish_o;
      case (phase_q)
        PH_OFF: if (start_i) begin
          phase_q <= PH_WAIT;
          busy_q  <= 1'b1;
          cnt_q   <= '0;
        end
        PH_WAIT: if (cyc_end_i) begin
          phase_q <= PH_PRESET;
          cnt_q   <= '0;
        end
        PH_PRESET: if (cyc_end_i) begin
          if (cnt_q == PRE_LAST) begin
            phase_q <= PH_SEARCH;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        PH_SEARCH: if (cyc_end_i) begin
          if (cnt_q == SRCH_LAST) begin
            phase_q <= PH_OFF;
            busy_q  <= 1'b0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: phase_q <= PH_OFF;
      endcase
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/offset_chan.sv
`timescale 1ns/1ps
module offset_chan #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              preset_i,
  input  logic              apply_i,
  input  logic              finish_i,
  input  logic [CODE_W-1:0] step_i,
  input  logic              sign_i,
  output logic [CODE_W-1:0] code_o,
  output logic              rail_o
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] TOP = '1;
  localparam logic [CODE_W-1:0] BOT = CODE_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      code_o <= MID;
      rail_o <= 1'b0;
    end else begin
      if (preset_i)      code_o <= MID;
      else if (apply_i)  code_o <= sign_i ? code_o + step_i : code_o - step_i;
      if (clr_i)         rail_o <= 1'b0;
      else if (finish_i) rail_o <= (code_o == TOP) || (code_o == BOT);
    end
  end
endmodule

// File: rtl/offset_search_ctrl.sv
`timescale 1ns/1ps
module offset_search_ctrl #(
  parameter int CODE_W     = 8,
  parameter int PRESET_CYC = 4,
  parameter int BASE_LOG2  = 7,
  parameter int SEL_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cal_start_i,
  input  logic              ext_sel_i,
  input  logic              int_tick_i,
  input  logic              ext_tick_i,
  input  logic [SEL_W-1:0]  div_sel_i,
  input  logic              sign_i_i,
  input  logic              sign_q_i,
  output logic [CODE_W-1:0] code_i_o,
  output logic [CODE_W-1:0] code_q_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              rail_i_o,
  output logic              rail_q_o
);
  localparam int NCH = 2;

  logic              cyc_end, accept, preset, apply, finish;
  logic [CODE_W-1:0] step;
  logic [NCH-1:0]    sign_v, rail_v;
  logic [CODE_W-1:0] code_v [NCH];

  offset_tick_div #(.BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W)) div_u (
    .clk(clk), .rst(rst), .load_i(accept), .run_i(busy_o),
    .sel_i(div_sel_i), .ext_sel_i(ext_sel_i),
    .int_tick_i(int_tick_i), .ext_tick_i(ext_tick_i),
    .cyc_end_o(cyc_end)
  );

  offset_seq #(.CODE_W(CODE_W), .PRESET_CYC(PRESET_CYC)) seq_u (
    .clk(clk), .rst(rst), .start_i(cal_start_i), .cyc_end_i(cyc_end),
    .busy_o(busy_o), .done_o(done_o), .accept_o(accept),
    .preset_o(preset), .apply_o(apply), .finish_o(finish), .step_o(step)
  );

  assign sign_v = {sign_q_i, sign_i_i};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    offset_chan #(.CODE_W(CODE_W)) ch_u (
      .clk(clk), .rst(rst), .clr_i(accept), .preset_i(preset),
      .apply_i(apply), .finish_i(finish), .step_i(step),
      .sign_i(sign_v[g]), .code_o(code_v[g]), .rail_o(rail_v[g])
    );
  end

  assign code_i_o = code_v[0];
  assign code_q_o = code_v[1];
  assign rail_i_o = rail_v[0];
  assign rail_q_o = rail_v[1];
endmodule

// File: rtl/offset_search_chk.sv
`timescale 1ns/1ps
module offset_search_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cal_start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [CODE_W-1:0] code_i_o,
  input logic [CODE_W-1:0] code_q_o,
  input logic              rail_i_o,
  input logic              rail_q_o
);
  localparam logic [CODE_W-1:0] TOP = '1;
  localparam logic [CODE_W-1:0] BOT = CODE_W'(1);

  // R8
  done_one_clk_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8
  busy_fall_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  // R2
  busy_rise_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(cal_start_i));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(busy_o) |-> ($stable(code_i_o) && $stable(code_q_o)));

  // R10
  code_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (code_i_o != '0) && (code_q_o != '0));

  // R9
  rail_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(rail_i_o) || $rose(rail_q_o)) |-> done_o);

  // R9
  rail_match_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ((rail_i_o == ((code_i_o == TOP) || (code_i_o == BOT))) &&
                (rail_q_o == ((code_q_o == TOP) || (code_q_o == BOT)))));
endmodule

bind offset_search_ctrl offset_search_chk #(.CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst(rst), .cal_start_i(cal_start_i), .busy_o(busy_o),
  .done_o(done_o), .code_i_o(code_i_o), .code_q_o(code_q_o),
  .rail_i_o(rail_i_o), .rail_q_o(rail_q_o)
);

// File: tb/offset_search_ctrl_tb_top.sv
`timescale 1ns/1ps
module offset_search_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cal_start = 1'b0;
  logic       ext_sel = 1'b1;
  logic       int_tick = 1'b0;
  logic       ext_tick = 1'b1;
  logic [1:0] div_sel = 2'd3;
  logic       sign_i, sign_q;
  logic [7:0] code_i, code_q;
  logic       busy, done, rail_i, rail_q;
  int         tgt_i = 128, tgt_q = 128;
  int         n_cmp = 0, n_bad = 0;
  int         int_div = 0;
  logic [17:0] exp_q [$];

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    int_div  <= (int_div == 2) ? 0 : int_div + 1;
    int_tick <= (int_div == 1);
  end

  // Detector model: code at or below the optimum leaves a positive or zero residual
  assign sign_i = (int'(code_i) <= tgt_i);
  assign sign_q = (int'(code_q) <= tgt_q);

  offset_search_ctrl dut_i (
    .clk(clk), .rst(rst), .cal_start_i(cal_start), .ext_sel_i(ext_sel),
    .int_tick_i(int_tick), .ext_tick_i(ext_tick), .div_sel_i(div_sel),
    .sign_i_i(sign_i), .sign_q_i(sign_q),
    .code_i_o(code_i), .code_q_o(code_q), .busy_o(busy), .done_o(done),
    .rail_i_o(rail_i), .rail_q_o(rail_q)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int search_model(input int t);
    int c = 128;
    for (int s = 64; s >= 1; s = s / 2) c = (c <= t) ? c + s : c - s;
    return c;
  endfunction

  // Monitor: pops one expected result per done pulse
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected done", 1, 0);
        end else begin
          logic [17:0] e;
          e = exp_q.pop_front();
          check(code_i == e[17:10], "R7 code I", code_i, e[17:10]);
          check(code_q == e[9:2],   "R7 code Q", code_q, e[9:2]);
          check(rail_i == e[1],     "R9 rail I", rail_i, e[1]);
          check(rail_q == e[0],     "R9 rail Q", rail_q, e[0]);
        end
      end
    end
  end

  // Driver: one calibration run
  task automatic run_cal(input int ti, input int tq, input logic [1:0] sel,
                         input bit use_ext, input bit chk_pre,
                         input bit poke_busy, input bit edge_start);
    int L, n, ci, cq, pi, pq;
    L  = 1024 >> sel;
    ci = search_model(ti);
    cq = search_model(tq);
    @(negedge clk);
    pi = code_i; pq = code_q;
    tgt_i = ti; tgt_q = tq;
    div_sel = sel;
    ext_sel = use_ext;
    ext_tick = use_ext;
    exp_q.push_back({ci[7:0], cq[7:0], (ci == 255 || ci == 1), (cq == 255 || cq == 1)});
    cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    n = 0;
    while (!done && n < 60000) begin
      @(negedge clk);
      n++;
      if (chk_pre && n == L - 1) begin
        check(code_i == pi, "R5 I held in first cycle", code_i, pi);
        check(code_q == pq, "R5 Q held in first cycle", code_q, pq);
        check(!rail_i && !rail_q, "R9 rails cleared by start", {rail_i, rail_q}, 0);
      end
      if (chk_pre && (n == L + 2 || n == 5 * L - 1)) begin
        check(code_i == 128, "R6 I midscale preset", code_i, 128);
        check(code_q == 128, "R6 Q midscale preset", code_q, 128);
      end
      if (poke_busy && n == 3 * L)     cal_start = 1'b1;
      if (poke_busy && n == 3 * L + 1) cal_start = 1'b0;
      if (edge_start && n == 13 * L - 1) cal_start = 1'b1;
      if (edge_start && n == 13 * L)     cal_start = 1'b0;
    end
    cal_start = 1'b0;
    if (use_ext)
      check(n == 13 * L, "R3 R8 sequence length", n, 13 * L);
    else
      check(n >= 39 * L - 3 && n <= 39 * L + 3, "R4 internal tick length", n, 39 * L);
    @(negedge clk);
    check(done == 1'b0, "R8 done is one clock", done, 0);
    check(busy == 1'b0, "R2 R8 idle after done", busy, 0);
    ext_tick = 1'b1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check(code_i == 128 && code_q == 128, "R1 reset codes", code_i, 128);
    check(!busy && !done && !rail_i && !rail_q, "R1 reset flags",
          {busy, done, rail_i, rail_q}, 0);
    rst = 1'b0;
    @(negedge clk);

    run_cal(100, 37, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0);   // R7 mid targets
    run_cal(255, 0, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0);    // R9 both rails
    run_cal(128, 127, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0);  // R2 start while busy, R7 zero residual
    run_cal(0, 255, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);    // R4 internal source
    run_cal(200, 5, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1);    // R3 div 1024, start at final edge
    run_cal(1, 254, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0);    // R10 low end

    begin
      int hi, hq;
      hi = code_i; hq = code_q;
      tgt_i = 0; tgt_q = 255;
      repeat (50) @(negedge clk);
      check(code_i == hi && code_q == hq, "R11 codes hold while idle", code_i, hi);
      check(code_i != 0 && code_q != 0, "R10 codes nonzero", code_i, 1);
      check(!busy, "R2 no queued start", busy, 0);
    end
    check(exp_q.size() == 0, "R8 every run completed", exp_q.size(), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #750000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule